// File: doc/BRIEF.md
# Dual-Mode Host Cycle Decoder

This block sits behind the host bus pins of a network controller that can be fitted either to an ISA slot or to a PC Card socket. It turns each host address and strobe pattern into select and sizing signals for the rest of the chip. While reset is held it samples a strap input to choose the bus mode. On ISA it drives an active-low boot ROM select. It drives an active-low 16-bit I/O indication for cycles that hit the LAN register window or the modem window. It also produces the modem power-down output and, on PC Card, a ready level.

Each output is a register. A result therefore appears one clock after the inputs that cause it. The LAN and modem register windows sit at fixed spans of 16 and 8 I/O addresses. Their bases come from configuration inputs. The ROM window takes both its base and its size from configuration inputs.

Top module: `host_cycle_decoder`

## Requirements
- R1: While `rst` is high the bus mode is taken from `strap_i` (0 = PC Card, 1 = ISA). Changes on `strap_i` after reset ends have no effect until the next reset.
- R2: In ISA mode `rom_sel_n_o` is 0 exactly when `mem_rd_n_i` is 0 and `addr_i` equals `rom_base_i` on every bit at or above position `rom_size_i`. A `rom_size_i` of `ADDR_W` matches every address. In PC Card mode `rom_sel_n_o` stays 1.
- R3: In PC Card mode a LAN hit requires a card enable to be low (`ce1_n_i` or `ce2_n_i`) and `addr_i[15:4]` equal to `lan_base_i`. For a LAN hit `io16_n_o` goes to 0 only when `bus16_i`, `func_en_i` and `!reg_sel_n_i` all hold.
- R4: In ISA mode a LAN hit needs only `addr_i[15:4] == lan_base_i`. For a LAN hit `io16_n_o` goes to 0 when `bus16_i` is 1. `func_en_i`, `reg_sel_n_i` and the card enables have no effect.
- R5: A modem hit requires `modem_cfg_i` = 1, `addr_i[15:3] == modem_base_i`, a card enable in PC Card mode, and no LAN hit. On a modem hit `io16_n_o` equals that cycle's `modem_w16_n_i` (0 = 16-bit modem).
- R6: `lan_sel_o` and `modem_sel_o` are never both 1. The LAN decode wins, and `overlap_o` is 1 when both decodes hit.
- R7: `modem_pwrdn_o` is 1 when `pwrdn_bit_i` is 1 or `modem_cfg_i` is 0.
- R8: In PC Card mode `ready_o` is 0 after reset. It goes to 1 one cycle after `cfg_done_i` is first seen, and it stays 1 even if `cfg_done_i` drops. In ISA mode `ready_o` stays 0.
- R9: While `rst` is high every output is inactive: `io16_n_o` and `rom_sel_n_o` are 1, and all other outputs are 0.
- R10: Every output reflects the inputs sampled at the previous rising clock edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | Bus mode strap, sampled during reset |
| addr_i | input | ADDR_W | Host address |
| mem_rd_n_i | input | 1 | Memory read strobe, active low |
| reg_sel_n_i | input | 1 | Attribute/register space select, active low |
| ce1_n_i | input | 1 | Card enable, even bytes, active low |
| ce2_n_i | input | 1 | Card enable, odd bytes, active low |
| bus16_i | input | 1 | Device runs in 16-bit mode |
| func_en_i | input | 1 | Function-enable bit of the configuration option register |
| lan_base_i | input | IO_W-LAN_SKIP | LAN I/O base, compared with address bits above the LAN span |
| modem_base_i | input | IO_W-MDM_SKIP | Modem I/O base, compared with address bits above the modem span |
| modem_cfg_i | input | 1 | Modem is configured |
| pwrdn_bit_i | input | 1 | Power-down control bit |
| modem_w16_n_i | input | 1 | Modem width, 0 = 16-bit |
| rom_base_i | input | ADDR_W | ROM window base |
| rom_size_i | input | SZ_W | Number of low address bits ignored by the ROM compare |
| cfg_done_i | input | 1 | Configuration load finished |
| io16_n_o | output | 1 | 16-bit I/O indication, active low |
| rom_sel_n_o | output | 1 | Boot ROM select, active low |
| lan_sel_o | output | 1 | LAN window selected |
| modem_sel_o | output | 1 | Modem window selected |
| overlap_o | output | 1 | Both windows hit |
| modem_pwrdn_o | output | 1 | Modem power-down |
| ready_o | output | 1 | PC Card ready level |

## Verification
The hardest cases to reach from the ports are the LAN/modem overlap and a ROM hit at every window size. A random address rarely lands in either one. The stimulus therefore draws most addresses from the LAN span, the modem span or near the ROM base. It switches the modem base between a spot inside the LAN span and a spot beside it. It also draws the ROM size uniformly from 0 to the full width. Both bus modes get a long sweep. In each sweep the strap toggles at random after reset, so every cycle also tests that the mode is held.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  typedef enum logic {
    MODE_PCCARD = 1'b0,
    MODE_ISA    = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/hcd_mode_ctl.sv
module hcd_mode_ctl
  import hcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      strap_i,
  input  logic      cfg_done_i,
  output bus_mode_e mode_o,
  output logic      ready_o
);
  bus_mode_e mode_q;
  logic      done_q;

  // Strap is sampled on every reset cycle; the last sample is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= bus_mode_e'(strap_i);
      done_q <= 1'b0;
    end else if (cfg_done_i) begin
      done_q <= 1'b1;
    end
  end

  assign mode_o  = mode_q;
  assign ready_o = (mode_q == MODE_PCCARD) && done_q;
endmodule

// File: rtl/hcd_win_match.sv
module hcd_win_match #(
  parameter int W  = 20,
  parameter int SW = 5
) (
  input  logic [W-1:0]  addr_i,
  input  logic [W-1:0]  base_i,
  input  logic [SW-1:0] skip_i,
  output logic          hit_o
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = (SW'(i) < skip_i) || (addr_i[i] == base_i[i]);
  end

  assign hit_o = &bit_ok;
endmodule

// File: rtl/host_cycle_decoder.sv
module host_cycle_decoder
  import hcd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int IO_W     = 16,
  parameter int LAN_SKIP = 4,
  parameter int MDM_SKIP = 3,
  parameter int SZ_W     = $clog2(ADDR_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strap_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     mem_rd_n_i,
  input  logic                     reg_sel_n_i,
  input  logic                     ce1_n_i,
  input  logic                     ce2_n_i,
  input  logic                     bus16_i,
  input  logic                     func_en_i,
  input  logic [IO_W-LAN_SKIP-1:0] lan_base_i,
  input  logic [IO_W-MDM_SKIP-1:0] modem_base_i,
  input  logic                     modem_cfg_i,
  input  logic                     pwrdn_bit_i,
  input  logic                     modem_w16_n_i,
  input  logic [ADDR_W-1:0]        rom_base_i,
  input  logic [SZ_W-1:0]          rom_size_i,
  input  logic                     cfg_done_i,
  output logic                     io16_n_o,
  output logic                     rom_sel_n_o,
  output logic                     lan_sel_o,
  output logic                     modem_sel_o,
  output logic                     overlap_o,
  output logic                     modem_pwrdn_o,
  output logic                     ready_o
);
  bus_mode_e mode;
  logic      is_isa;
  logic      rom_hit, card_on, lan_hit, mdm_raw, mdm_hit, io16_req, io16_lan;

  hcd_mode_ctl u_mode (
    .clk        (clk),
    .rst        (rst),
    .strap_i    (strap_i),
    .cfg_done_i (cfg_done_i),
    .mode_o     (mode),
    .ready_o    (ready_o)
  );

  hcd_win_match #(.W(ADDR_W), .SW(SZ_W)) u_rom_win (
    .addr_i (addr_i),
    .base_i (rom_base_i),
    .skip_i (rom_size_i),
    .hit_o  (rom_hit)
  );

  assign is_isa   = (mode == MODE_ISA);
  assign card_on  = is_isa || !ce1_n_i || !ce2_n_i;
  assign lan_hit  = card_on && (addr_i[IO_W-1:LAN_SKIP] == lan_base_i);
  assign mdm_raw  = card_on && modem_cfg_i && (addr_i[IO_W-1:MDM_SKIP] == modem_base_i);
  assign mdm_hit  = mdm_raw && !lan_hit;
  assign io16_lan = lan_hit && bus16_i && (is_isa || (func_en_i && !reg_sel_n_i));
  assign io16_req = io16_lan || (mdm_hit && !modem_w16_n_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      io16_n_o      <= 1'b1;
      rom_sel_n_o   <= 1'b1;
      lan_sel_o     <= 1'b0;
      modem_sel_o   <= 1'b0;
      overlap_o     <= 1'b0;
      modem_pwrdn_o <= 1'b0;
    end else begin
      io16_n_o      <= !io16_req;
      rom_sel_n_o   <= !(is_isa && !mem_rd_n_i && rom_hit);
      lan_sel_o     <= lan_hit;
      modem_sel_o   <= mdm_hit;
      overlap_o     <= lan_hit && mdm_raw;
      modem_pwrdn_o <= pwrdn_bit_i || !modem_cfg_i;
    end
  end

  assert_mode_held_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(mode));
  assert_rom_isa_only_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PCCARD) |-> rom_sel_n_o);
  assert_io16_qualified_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PCCARD && lan_sel_o && !io16_n_o)
      |-> $past(bus16_i && func_en_i && !reg_sel_n_i));
  assert_sel_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(lan_sel_o && modem_sel_o));
  assert_overlap_lan_R6: assert property (@(posedge clk) disable iff (rst)
    overlap_o |-> lan_sel_o);
  assert_pwrdn_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (modem_pwrdn_o == $past(pwrdn_bit_i || !modem_cfg_i)));
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !$fell(ready_o));
  assert_ready_isa_low_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ISA) |-> !ready_o);
endmodule

// File: tb/tb_host_cycle_decoder.sv
`timescale 1ns/1ps
module tb_host_cycle_decoder;
  localparam int ADDR_W = 20;
  localparam int SZ_W   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic mem_rd_n_i = 1'b1, reg_sel_n_i = 1'b1, ce1_n_i = 1'b1, ce2_n_i = 1'b1;
  logic bus16_i = 1'b0, func_en_i = 1'b0, modem_cfg_i = 1'b0, pwrdn_bit_i = 1'b0;
  logic modem_w16_n_i = 1'b1, cfg_done_i = 1'b0;
  logic [11:0] lan_base_i = 12'h030;
  logic [12:0] modem_base_i = 13'h0062;
  logic [ADDR_W-1:0] rom_base_i = 20'hC8000;
  logic [SZ_W-1:0] rom_size_i = 5'd14;
  logic io16_n_o, rom_sel_n_o, lan_sel_o, modem_sel_o, overlap_o, modem_pwrdn_o, ready_o;

  int checks = 0;
  int errors = 0;
  bit isa;

  always #2.5 clk = ~clk;

  host_cycle_decoder dut (
    .clk(clk), .rst(rst), .strap_i(strap_i), .addr_i(addr_i),
    .mem_rd_n_i(mem_rd_n_i), .reg_sel_n_i(reg_sel_n_i),
    .ce1_n_i(ce1_n_i), .ce2_n_i(ce2_n_i), .bus16_i(bus16_i),
    .func_en_i(func_en_i), .lan_base_i(lan_base_i), .modem_base_i(modem_base_i),
    .modem_cfg_i(modem_cfg_i), .pwrdn_bit_i(pwrdn_bit_i),
    .modem_w16_n_i(modem_w16_n_i), .rom_base_i(rom_base_i),
    .rom_size_i(rom_size_i), .cfg_done_i(cfg_done_i),
    .io16_n_o(io16_n_o), .rom_sel_n_o(rom_sel_n_o), .lan_sel_o(lan_sel_o),
    .modem_sel_o(modem_sel_o), .overlap_o(overlap_o),
    .modem_pwrdn_o(modem_pwrdn_o), .ready_o(ready_o)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (isa=%0b addr=%h)", req, act, exp, isa, addr_i);
    end
  endtask

  task automatic do_reset(bit strap);
    @(negedge clk);
    rst = 1'b1; strap_i = strap; cfg_done_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    isa = strap;
  endtask

  // Expected outputs from the requirements, for the current inputs.
  task automatic check_vector();
    logic [ADDR_W-1:0] mask;
    logic rom, card, lan, mraw, msel, io16;
    mask = (rom_size_i >= ADDR_W) ? '0 : ({ADDR_W{1'b1}} << rom_size_i);
    rom  = isa && !mem_rd_n_i && ((addr_i & mask) == (rom_base_i & mask));
    card = isa || !ce1_n_i || !ce2_n_i;
    lan  = card && (addr_i[15:4] == lan_base_i);
    mraw = card && modem_cfg_i && (addr_i[15:3] == modem_base_i);
    msel = mraw && !lan;
    io16 = (lan && bus16_i && (isa || (func_en_i && !reg_sel_n_i))) || (msel && !modem_w16_n_i);
    @(negedge clk);
    check("R2 rom select (R1 mode held)", rom_sel_n_o, !rom);
    if (isa) check("R4 io16 isa", io16_n_o, !io16);
    else     check("R3 io16 pccard", io16_n_o, !io16);
    if (msel) check("R5 io16 modem width", io16_n_o, modem_w16_n_i);
    check("R6 lan select", lan_sel_o, lan);
    check("R6 modem select", modem_sel_o, msel);
    check("R6 overlap", overlap_o, lan && mraw);
    check("R7 modem pwrdn", modem_pwrdn_o, pwrdn_bit_i || !modem_cfg_i);
  endtask

  task automatic sweep(int n);
    for (int i = 0; i < n; i++) begin
      int sel;
      sel = int'($urandom % 4);
      strap_i       = 1'($urandom);
      mem_rd_n_i    = 1'($urandom);
      reg_sel_n_i   = 1'($urandom);
      ce1_n_i       = 1'($urandom);
      ce2_n_i       = 1'($urandom);
      bus16_i       = 1'($urandom);
      func_en_i     = 1'($urandom);
      modem_cfg_i   = 1'($urandom);
      pwrdn_bit_i   = 1'($urandom);
      modem_w16_n_i = 1'($urandom);
      modem_base_i  = ($urandom % 2 == 0) ? 13'h0060 : 13'h0062;
      rom_size_i    = SZ_W'($urandom % (ADDR_W + 1));
      case (sel)
        0:       addr_i = 20'h00300 + 20'($urandom % 16);
        1:       addr_i = 20'h00310 + 20'($urandom % 8);
        2:       addr_i = rom_base_i ^ 20'($urandom % 65536);
        default: addr_i = 20'($urandom);
      endcase
      check_vector();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: active-looking inputs held during reset.
    isa = 1'b1;
    addr_i = 20'hC8000; mem_rd_n_i = 1'b0; pwrdn_bit_i = 1'b1; bus16_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reset io16", io16_n_o, 1'b1);
    check("R9 reset rom", rom_sel_n_o, 1'b1);
    check("R9 reset pwrdn", modem_pwrdn_o, 1'b0);
    check("R9 reset ready", ready_o, 1'b0);
    check("R9 reset lan", lan_sel_o, 1'b0);

    // ISA mode: R10 latency, R8 ready stays low.
    do_reset(1'b1);
    addr_i = 20'hC8010; mem_rd_n_i = 1'b1;
    @(negedge clk);
    mem_rd_n_i = 1'b0;
    #1;
    check("R10 no change before edge", rom_sel_n_o, 1'b1);
    @(negedge clk);
    check("R10 rom after one edge", rom_sel_n_o, 1'b0);
    cfg_done_i = 1'b1;
    @(negedge clk); cfg_done_i = 1'b0;
    @(negedge clk);
    check("R8 isa ready low", ready_o, 1'b0);
    sweep(3000);

    // PC Card mode.
    do_reset(1'b0);
    strap_i = 1'b1;
    addr_i = 20'hC8000; mem_rd_n_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 strap ignored after reset", rom_sel_n_o, 1'b1);
    check("R8 ready low before cfg", ready_o, 1'b0);
    cfg_done_i = 1'b1;
    @(negedge clk); cfg_done_i = 1'b0;
    check("R8 ready high after cfg", ready_o, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 ready sticky", ready_o, 1'b1);
    // R3 corner: all qualifiers except register select.
    addr_i = 20'h00305; ce1_n_i = 1'b0; bus16_i = 1'b1; func_en_i = 1'b1; reg_sel_n_i = 1'b1;
    modem_cfg_i = 1'b0;
    @(negedge clk);
    check("R3 reg select high blocks io16", io16_n_o, 1'b1);
    check("R3 lan hit with card enable", lan_sel_o, 1'b1);
    sweep(3000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule